// File: doc/BRIEF.md
# Fan PWM Generator with Programmable Edge Points

This block drives one fan PWM output from the system clock. A two-stage prescaler produces a count tick. The first stage divides by a power of two. The second stage divides by a linear amount. Each tick advances a period counter that runs from zero up to a programmed terminal value and then wraps. The output is set when the counter reaches a programmed rise position and cleared when it reaches a programmed fall position. Because of this, both the duty and the phase of the pulse can be placed anywhere in the period.

The divider settings, the terminal count and the two edge positions are plain inputs. The block treats them as shadow values and copies them into its working registers only at a period boundary, so a setting changed in mid-period never shortens or splits a pulse. A global count enable freezes the whole time base. A separate output enable forces the pin low without disturbing the counting. A one-cycle strobe marks the first clock of every period.

Top module: `fan_pwm_edge`

## Requirements
- R1: With dividers giving D clocks per tick and terminal count P, the distance between two consecutive period strobes is D*(P+1) clocks.
- R2: The exponent input `div_exp` gives a first-stage division of 2^div_exp, for values 0 to 15.
- R3: The linear input `div_lin` gives a second-stage division of 1 when it is 0, and of 2*n when it is a nonzero value n. D is the product of the two stages.
- R4: `duty_pts[7:0]` is the rise position and `duty_pts[15:8]` is the fall position. The output goes high in the count where the counter equals the rise position and low in the count where it equals the fall position. When rise is below fall, the output is high for (fall-rise)*D clocks of each period. When rise is above fall, the pulse wraps around the period end and the output is high for (fall+P+1-rise)*D clocks.
- R5: Equal rise and fall positions, including both zero, hold the output high for the whole period.
- R6: While `port_en` is low, `pwm_out` is low.
- R7: While `clk_en` is low, the prescaler and the period counter hold, so no strobe appears and the output does not change.
- R8: `period_start` is a single-cycle pulse that goes high in the first clock of each period, once per period.
- R9: New divider, terminal-count and edge values take effect only at the next period boundary. A period already in progress completes with the old values.
- R10: Reset (active-low, asynchronous) clears all counters and working registers and drives `pwm_out` and `period_start` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Global count enable for the prescaler and the period counter |
| port_en | input | 1 | Output enable; low forces the output low |
| div_exp | input | 4 | First-stage exponent, division 2^div_exp |
| div_lin | input | 4 | Second-stage setting, 0 gives /1 and n gives /2n |
| period | input | 8 | Terminal count P of the period counter |
| duty_pts | input | 16 | Rise position in [7:0], fall position in [15:8] |
| pwm_out | output | 1 | PWM waveform |
| period_start | output | 1 | One-cycle strobe in the first clock of each period |

## Verification
On every cycle, the embedded assertions check four things. The counter never passes the working terminal count. The counter is frozen while the count enable is low. Working settings change only together with the period strobe, and the strobe marks count zero. Every rising or falling edge of the internal level lines up with the matching compare position. The bench scenarios are needed for the properties that span whole periods: the period length for each divider combination, the high time in the plain and wrapped cases, full duty for equal positions, the output mask, and the check that a mid-period change leaves the running period intact.

// File: rtl/fan_pwm_edge.sv
module fan_pwm_edge #(
  parameter int EXP_W = 4,
  parameter int LIN_W = 4,
  parameter int PER_W = 8,
  parameter int PT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              port_en,
  input  logic [EXP_W-1:0]  div_exp,
  input  logic [LIN_W-1:0]  div_lin,
  input  logic [PER_W-1:0]  period,
  input  logic [2*PT_W-1:0] duty_pts,
  output logic              pwm_out,
  output logic              period_start
);

  localparam int HI_CW = (1 << EXP_W) - 1;
  localparam int LO_CW = LIN_W + 1;

  logic [EXP_W-1:0] exp_act;
  logic [LIN_W-1:0] lin_act;
  logic [PER_W-1:0] per_act;
  logic [PT_W-1:0]  rise_act, fall_act;

  logic [HI_CW-1:0] hi_cnt, hi_last;
  logic [LO_CW-1:0] lo_cnt, lo_last;
  logic [PER_W-1:0] cnt, cnt_nxt;
  logic             pwm_q, lvl_nxt;
  logic             hi_wrap, tick, wrap;
  logic [PT_W-1:0]  rise_use, fall_use;

  assign hi_last = (HI_CW'(1) << exp_act) - HI_CW'(1);
  assign lo_last = (lin_act == '0) ? '0 : ({1'b0, lin_act} << 1) - LO_CW'(1);

  assign hi_wrap = clk_en && (hi_cnt == hi_last);
  assign tick    = hi_wrap && (lo_cnt == lo_last);
  assign wrap    = tick && (cnt == per_act);

  assign cnt_nxt  = wrap ? '0 : cnt + PER_W'(1);
  assign rise_use = wrap ? duty_pts[PT_W-1:0]      : rise_act;
  assign fall_use = wrap ? duty_pts[2*PT_W-1:PT_W] : fall_act;

  always_comb begin
    if (rise_use == fall_use)    lvl_nxt = 1'b1;
    else if (cnt_nxt == rise_use) lvl_nxt = 1'b1;
    else if (cnt_nxt == fall_use) lvl_nxt = 1'b0;
    else                          lvl_nxt = pwm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt       <= '0;
      lo_cnt       <= '0;
      cnt          <= '0;
      pwm_q        <= 1'b0;
      period_start <= 1'b0;
      exp_act      <= '0;
      lin_act      <= '0;
      per_act      <= '0;
      rise_act     <= '0;
      fall_act     <= '0;
    end else begin
      period_start <= wrap;
      if (clk_en)
        hi_cnt <= hi_wrap ? '0 : hi_cnt + HI_CW'(1);
      if (hi_wrap)
        lo_cnt <= (lo_cnt == lo_last) ? '0 : lo_cnt + LO_CW'(1);
      if (tick) begin
        cnt   <= cnt_nxt;
        pwm_q <= lvl_nxt;
      end
      if (wrap) begin
        exp_act  <= div_exp;
        lin_act  <= div_lin;
        per_act  <= period;
        rise_act <= duty_pts[PT_W-1:0];
        fall_act <= duty_pts[2*PT_W-1:PT_W];
      end
    end
  end

  assign pwm_out = port_en & pwm_q;

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_act);

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(cnt) && $stable(pwm_q));

  assert_start_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> cnt == '0);

  assert_shadow_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> $stable(rise_act) && $stable(fall_act));

  assert_shadow_per_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> $stable(per_act) && $stable(exp_act) && $stable(lin_act));

  assert_rise_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_q) |-> (PT_W'(cnt) == rise_act) || (rise_act == fall_act));

  assert_fall_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_q) |-> (PT_W'(cnt) == fall_act) && (rise_act != fall_act));

endmodule

// File: tb/sim_fan_pwm_edge.sv
module sim_fan_pwm_edge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b0;
  logic        port_en = 1'b0;
  logic [3:0]  div_exp = '0;
  logic [3:0]  div_lin = '0;
  logic [7:0]  period = '0;
  logic [15:0] duty_pts = '0;
  logic        pwm_out, period_start;

  int n_run = 0;
  int n_fail = 0;

  int    q_tot[$];
  int    q_high[$];
  string q_tag[$];
  bit    meas = 1'b0;
  int    wc = 0;
  int    hc = 0;

  always #2 clk = ~clk;

  fan_pwm_edge u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .port_en(port_en),
    .div_exp(div_exp), .div_lin(div_lin), .period(period),
    .duty_pts(duty_pts), .pwm_out(pwm_out), .period_start(period_start)
  );

  task automatic check(input string tag, input int act, input int exp_v);
    n_run++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (period_start) begin
      if (meas) begin
        n_run++;
        if (wc != q_tot[0] || hc != q_high[0]) begin
          n_fail++;
          $display("FAIL %s actual clocks=%0d high=%0d expected clocks=%0d high=%0d",
                   q_tag[0], wc, hc, q_tot[0], q_high[0]);
        end
        void'(q_tot.pop_front());
        void'(q_high.pop_front());
        void'(q_tag.pop_front());
        meas = 1'b0;
      end
      if (q_tot.size() > 0) begin
        meas = 1'b1;
        wc = 0;
        hc = 0;
      end
    end
    if (meas) begin
      wc++;
      if (pwm_out) hc++;
    end
  end

  task automatic set_cfg(input int e, input int l, input int p, input int r, input int f);
    div_exp  = 4'(e);
    div_lin  = 4'(l);
    period   = 8'(p);
    duty_pts = {8'(f), 8'(r)};
  endtask

  task automatic drain();
    while (q_tot.size() != 0 || meas) @(negedge clk);
  endtask

  task automatic push_exp(input int tot, input int high, input string tag);
    q_tot.push_back(tot);
    q_high.push_back(high);
    q_tag.push_back(tag);
  endtask

  task automatic expect_window(input int tot, input int high, input string tag);
    @(negedge clk iff period_start);
    @(negedge clk iff period_start);
    @(posedge clk);
    #1;
    push_exp(tot, high, tag);
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int pulses;
    int changes;
    logic hold;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 pwm_out after reset", int'(pwm_out), 0);
    check("R10 period_start after reset", int'(period_start), 0);

    clk_en = 1'b1;
    port_en = 1'b1;

    set_cfg(0, 0, 9, 2, 7);
    expect_window(10, 5, "R1 R4 D=1 P=9 rise<fall");

    set_cfg(2, 0, 9, 2, 7);
    expect_window(40, 20, "R2 exp=2 gives D=4");

    set_cfg(0, 3, 4, 1, 3);
    expect_window(30, 12, "R3 lin=3 gives D=6");

    set_cfg(1, 2, 7, 6, 2);
    expect_window(64, 32, "R4 wrapped pulse D=8");

    set_cfg(0, 0, 9, 0, 0);
    expect_window(10, 10, "R5 rise=fall=0 full duty");

    set_cfg(0, 0, 9, 5, 5);
    expect_window(10, 10, "R5 rise=fall=5 full duty");

    set_cfg(0, 0, 9, 2, 7);
    port_en = 1'b0;
    expect_window(10, 0, "R6 output masked");
    port_en = 1'b1;

    set_cfg(0, 0, 9, 2, 7);
    expect_window(10, 5, "R9 setup window");
    push_exp(10, 5, "R9 mid-period change ignored");
    while (!meas) @(negedge clk);
    repeat (3) @(negedge clk);
    set_cfg(1, 0, 4, 0, 9);
    drain();
    set_cfg(0, 0, 9, 2, 7);
    expect_window(10, 5, "R9 restored window");

    pulses = 0;
    repeat (100) begin
      @(negedge clk);
      if (period_start) pulses++;
    end
    check("R8 one strobe per 10-clock period", pulses, 10);

    @(negedge clk);
    clk_en = 1'b0;
    @(negedge clk);
    hold = pwm_out;
    pulses = 0;
    changes = 0;
    repeat (100) begin
      @(negedge clk);
      if (period_start) pulses++;
      if (pwm_out != hold) changes++;
    end
    check("R7 no strobe while frozen", pulses, 0);
    check("R7 output held while frozen", changes, 0);
    clk_en = 1'b1;
    expect_window(10, 5, "R7 resumes after enable");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule